// File: doc/BRIEF.md
# Collision-Sensing Transmit Controller for a Shared Half-Duplex Serial Line

This block is the transmit side of a node on a two-wire, half-duplex serial bus that any node may drive. It takes bytes from a host through a valid/ready handshake and sends each one as an asynchronous character. A character is one low start bit, eight data bits with the least significant bit first, and one high stop bit. The bit time is set by a clocks-per-bit parameter.

Bus access follows a carrier-sense, collision-detect scheme. The block reads one status input, `busFree`, which is high while nobody drives the line and low while someone does. That input passes through a two-stage synchronizer. The block starts a message only after the synchronized status has stayed high for a whole qualification window. After every stop bit it samples the status once. A low reading there means a collision: the message is dropped, a burst of all-zero jam characters is sent so that every node sees the conflict, and the block reports an abort. A retry, if any, is the host's decision.

The external driver has its data pin tied low. The driver enable output is the inverse of the serial data, so the line is pulled only during zero bits and is let go at once for ones and when idle. A self-test drives the line low for one bit time and checks whether the status input follows.

Top module: `csma_bus_tx`

## Requirements
- R1: While reset is held, and right after it, `txSerial` is 1, `drvEnable` is 0, and `reqReady`, `rxIntMask`, `sendDone`, `sendAbort`, `testDone`, `collisionFlag` and `lineFault` are all 0.
- R2: Each character on `txSerial` is a start bit of 0, then the eight data bits with bit 0 first, then a stop bit of 1. Every bit lasts exactly `CLKS_PER_BIT` clock cycles.
- R3: In every cycle `drvEnable` is the logical inverse of `txSerial`.
- R4: No start bit begins until the synchronized `busFree` has been high for `IDLE_BITS*CLKS_PER_BIT` consecutive cycles. Any low reading restarts that count. When the bus becomes free while a request waits, the first start bit follows within `IDLE_BITS*CLKS_PER_BIT+5` cycles.
- R5: The host offers each byte with `reqValid`, and the byte is taken in a cycle where both `reqValid` and `reqReady` are high. `reqLast` marks the final byte. A message whose stop-bit samples all read the bus free ends with a one-cycle `sendDone` pulse.
- R6: If the sample after any stop bit reads the bus busy, the rest of the message is not sent. Instead `JAM_BYTES` characters of 0x00 follow back to back, and then a one-cycle `sendAbort` pulse is given. `collisionFlag` goes high at the detection and stays high until the first byte of a later message is taken.
- R7: `rxIntMask` is high whenever the block drives the line. It is high from the moment the bus is won until the message completes or aborts, and it is low while the block is idle.
- R8: A `selfTestGo` pulse while idle drives `txSerial` low for one bit time and then gives a `testDone` pulse. `lineFault` is set to 1 if the synchronized status still read free at the end of that bit, and is cleared to 0 otherwise.
- R9: `selfTestGo` has no effect while a message is in progress: no `testDone`, no change to `lineFault`, and no change to the characters sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host offers a byte |
| reqData | input | 8 | Byte offered by the host |
| reqLast | input | 1 | Offered byte is the last of the message |
| reqReady | output | 1 | Block takes the offered byte this cycle |
| selfTestGo | input | 1 | Start a line self-test (acted on only when idle) |
| busFree | input | 1 | Bus status: 1 = idle, 0 = occupied |
| txSerial | output | 1 | Serial character stream, idle high |
| drvEnable | output | 1 | Line driver enable, high only for zero bits |
| rxIntMask | output | 1 | Masks the local receive interrupt while sending |
| sendDone | output | 1 | One-cycle pulse: message sent without collision |
| sendAbort | output | 1 | One-cycle pulse: message aborted after the jam |
| collisionFlag | output | 1 | Last message ended in a collision |
| lineFault | output | 1 | Last self-test found the status did not follow the drive |
| testDone | output | 1 | One-cycle pulse: self-test finished |

## Verification
The assertions check several properties on every cycle. Whenever the line is pulled low, the receive mask is high. A new character is never loaded while one is still shifting, except in the cycle it ends. A stop bit ends high. A fall of the synchronized status clears the idle qualification on the next cycle. A done pulse follows only a free sample, and an abort only comes with the collision flag raised. The rest can only be shown by the bench's scenarios: the bit order and timing of every one of the 256 byte values; the bounds on start latency after the bus frees up, including a short free gap that must not win the bus; the exact number of jam characters after a collision timed into a stop bit; and the fault verdicts of the self-test on a working and a broken line.

// File: rtl/csma_bus_pkg.sv
package csma_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LISTEN,
    ST_LOAD,
    ST_SEND,
    ST_CHECK,
    ST_JAM,
    ST_TEST
  } ctrlState_t;

  // strobes from the sequencer to the shifter
  typedef struct packed {
    logic loadByte;  // start a character carrying the host byte
    logic loadZero;  // start a character carrying 0x00 (jam)
    logic loadTest;  // drive a single low bit for the self-test
  } dpCmd_t;

  localparam int FRAME_BITS = 10;

endpackage

// File: rtl/csma_tx_datapath.sv
module csma_tx_datapath
  import csma_bus_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  parameter int IDLE_BITS    = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic [7:0] byteIn,
  input  logic       busFreeIn,
  output logic       busFreeSync,
  output logic       idleOk,
  output logic       frameEnd,
  output logic       txBit
);

  localparam int IDLE_CYCLES = IDLE_BITS * CLKS_PER_BIT;
  localparam int TW = $clog2(CLKS_PER_BIT + 1);
  localparam int IW = $clog2(IDLE_CYCLES + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam logic [TW-1:0] TIMER_LAST = TW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CYCLES);
  localparam logic [BW-1:0] FULL_LAST = BW'(FRAME_BITS - 1);

  logic [1:0]            syncReg;
  logic [IW-1:0]         idleCnt;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [BW-1:0]         bitIdx;
  logic [BW-1:0]         lastIdx;
  logic [TW-1:0]         timer;
  logic                  active;
  logic                  anyLoad;

  // two-stage synchronizer; reset value reads as occupied
  always_ff @(posedge clk) begin
    if (!rstN) syncReg <= 2'b00;
    else       syncReg <= {syncReg[0], busFreeIn};
  end
  assign busFreeSync = syncReg[1];

  // consecutive-free counter, saturating at the qualification window
  always_ff @(posedge clk) begin
    if (!rstN)               idleCnt <= '0;
    else if (!busFreeSync)   idleCnt <= '0;
    else if (idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
  end
  assign idleOk = (idleCnt == IDLE_MAX);

  assign anyLoad  = cmd.loadByte | cmd.loadZero | cmd.loadTest;
  assign frameEnd = active && (timer == TIMER_LAST) && (bitIdx == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      timer    <= '0;
      bitIdx   <= '0;
      lastIdx  <= FULL_LAST;
      shiftReg <= '1;
    end else if (anyLoad) begin
      active  <= 1'b1;
      timer   <= '0;
      bitIdx  <= '0;
      if (cmd.loadTest) begin
        shiftReg <= '0;
        lastIdx  <= '0;
      end else begin
        shiftReg <= {1'b1, (cmd.loadZero ? 8'h00 : byteIn), 1'b0};
        lastIdx  <= FULL_LAST;
      end
    end else if (active) begin
      if (timer == TIMER_LAST) begin
        timer <= '0;
        if (bitIdx == lastIdx) begin
          active <= 1'b0;
        end else begin
          bitIdx   <= bitIdx + 1'b1;
          shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
        end
      end else begin
        timer <= timer + 1'b1;
      end
    end
  end

  assign txBit = active ? shiftReg[0] : 1'b1;

  // the sequencer never starts a character over a running one
  assert_load_when_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |-> (!active || frameEnd));

  // a full character always closes on a high stop bit
  assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && lastIdx == FULL_LAST) |-> txBit);

  // any busy reading drops the idle qualification on the next cycle
  assert_idle_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busFreeSync) |=> !idleOk);

endmodule

// File: rtl/csma_tx_control.sv
module csma_tx_control
  import csma_bus_pkg::*;
#(
  parameter int JAM_BYTES = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqLast,
  output logic   reqReady,
  input  logic   selfTestGo,
  input  logic   busFreeSync,
  input  logic   idleOk,
  input  logic   frameEnd,
  output dpCmd_t cmd,
  output logic   sendDone,
  output logic   sendAbort,
  output logic   collisionFlag,
  output logic   lineFault,
  output logic   testDone,
  output logic   rxIntMask
);

  localparam int JW = $clog2(JAM_BYTES + 1);
  localparam logic [JW-1:0] JAM_FIRST = JW'(JAM_BYTES - 1);

  ctrlState_t state, nextState;
  logic [JW-1:0] jamLeft;
  logic          lastPend;
  logic          collide;

  assign collide = (state == ST_CHECK) && !busFreeSync;

  always_comb begin
    nextState = state;
    cmd       = '0;
    reqReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (selfTestGo) begin
          cmd.loadTest = 1'b1;
          nextState    = ST_TEST;
        end else if (reqValid) begin
          nextState = ST_LISTEN;
        end
      end
      ST_LISTEN: begin
        if (!reqValid)   nextState = ST_IDLE;
        else if (idleOk) nextState = ST_LOAD;
      end
      ST_LOAD: begin
        reqReady = 1'b1;
        if (reqValid) begin
          cmd.loadByte = 1'b1;
          nextState    = ST_SEND;
        end
      end
      ST_SEND: begin
        if (frameEnd) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (!busFreeSync) begin
          cmd.loadZero = 1'b1;
          nextState    = ST_JAM;
        end else if (lastPend) begin
          nextState = ST_IDLE;
        end else begin
          nextState = ST_LOAD;
        end
      end
      ST_JAM: begin
        if (frameEnd) begin
          if (jamLeft == '0) nextState = ST_IDLE;
          else               cmd.loadZero = 1'b1;
        end
      end
      ST_TEST: begin
        if (frameEnd) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      jamLeft       <= '0;
      lastPend      <= 1'b0;
      sendDone      <= 1'b0;
      sendAbort     <= 1'b0;
      testDone      <= 1'b0;
      collisionFlag <= 1'b0;
      lineFault     <= 1'b0;
    end else begin
      state     <= nextState;
      sendDone  <= (state == ST_CHECK) && busFreeSync && lastPend;
      sendAbort <= (state == ST_JAM) && frameEnd && (jamLeft == '0);
      testDone  <= (state == ST_TEST) && frameEnd;
      if (cmd.loadByte) lastPend <= reqLast;
      if ((state == ST_TEST) && frameEnd) lineFault <= busFreeSync;
      if (collide) begin
        collisionFlag <= 1'b1;
        jamLeft       <= JAM_FIRST;
      end else if ((state == ST_JAM) && frameEnd && (jamLeft != '0)) begin
        jamLeft <= jamLeft - 1'b1;
      end
      if ((state == ST_LISTEN) && (nextState == ST_LOAD)) collisionFlag <= 1'b0;
    end
  end

  assign rxIntMask = (state == ST_LOAD) || (state == ST_SEND) || (state == ST_CHECK) ||
                     (state == ST_JAM)  || (state == ST_TEST);

  // success is only reported after a free stop-bit sample
  assert_done_after_free_R5: assert property (@(posedge clk) disable iff (!rstN)
    sendDone |-> $past(busFreeSync));

  // an abort is always accompanied by the collision flag
  assert_abort_flagged_R6: assert property (@(posedge clk) disable iff (!rstN)
    sendAbort |-> collisionFlag);

  assert_done_abort_apart_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(sendDone && sendAbort));

  // winning the bus requires the qualified idle window
  assert_win_needs_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(reqReady) && $past(state == ST_LISTEN)) |-> $past(idleOk));

endmodule

// File: rtl/csma_bus_tx.sv
module csma_bus_tx
  import csma_bus_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434,
  parameter int IDLE_BITS    = 10,
  parameter int JAM_BYTES    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [7:0] reqData,
  input  logic       reqLast,
  output logic       reqReady,
  input  logic       selfTestGo,
  input  logic       busFree,
  output logic       txSerial,
  output logic       drvEnable,
  output logic       rxIntMask,
  output logic       sendDone,
  output logic       sendAbort,
  output logic       collisionFlag,
  output logic       lineFault,
  output logic       testDone
);

  dpCmd_t dpCmd;
  logic   busFreeSync;
  logic   idleOk;
  logic   frameEnd;
  logic   txBit;

  csma_tx_datapath #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .IDLE_BITS   (IDLE_BITS)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (dpCmd),
    .byteIn     (reqData),
    .busFreeIn  (busFree),
    .busFreeSync(busFreeSync),
    .idleOk     (idleOk),
    .frameEnd   (frameEnd),
    .txBit      (txBit)
  );

  csma_tx_control #(
    .JAM_BYTES(JAM_BYTES)
  ) uControl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqLast      (reqLast),
    .reqReady     (reqReady),
    .selfTestGo   (selfTestGo),
    .busFreeSync  (busFreeSync),
    .idleOk       (idleOk),
    .frameEnd     (frameEnd),
    .cmd          (dpCmd),
    .sendDone     (sendDone),
    .sendAbort    (sendAbort),
    .collisionFlag(collisionFlag),
    .lineFault    (lineFault),
    .testDone     (testDone),
    .rxIntMask    (rxIntMask)
  );

  // driver data pin is tied low off-chip; enabling it sends a zero
  assign txSerial  = txBit;
  assign drvEnable = ~txBit;

  // the local receiver is masked whenever this node pulls the line
  assert_drive_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    !txSerial |-> rxIntMask);

endmodule

// File: tb/csma_bus_tx_test.sv
`timescale 1ns/1ps
module csma_bus_tx_test;

  localparam int CPB   = 4;
  localparam int IBITS = 3;
  localparam int JAM   = 2;
  localparam int IWIN  = IBITS * CPB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [7:0] reqData = 8'h00;
  logic reqLast = 1'b0;
  logic selfTestGo = 1'b0;
  logic extBusy = 1'b0;
  logic lineBroken = 1'b0;
  logic busFree;
  logic reqReady, txSerial, drvEnable, rxIntMask;
  logic sendDone, sendAbort, collisionFlag, lineFault, testDone;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // wired bus: low when this node or another node pulls it
  assign busFree = lineBroken ? 1'b1 : (!drvEnable && !extBusy);

  csma_bus_tx #(.CLKS_PER_BIT(CPB), .IDLE_BITS(IBITS), .JAM_BYTES(JAM)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqData(reqData), .reqLast(reqLast),
    .reqReady(reqReady), .selfTestGo(selfTestGo), .busFree(busFree), .txSerial(txSerial),
    .drvEnable(drvEnable), .rxIntMask(rxIntMask), .sendDone(sendDone), .sendAbort(sendAbort),
    .collisionFlag(collisionFlag), .lineFault(lineFault), .testDone(testDone)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // line monitor: decodes characters mid-bit, tallies per-cycle rules
  logic [7:0] dec [0:511];
  int nDec = 0;
  int frameErrs = 0;
  int r3Bad = 0;
  int r7Bad = 0;
  int nTest = 0;
  bit inFrame = 0;
  int monCnt = 0;
  logic [9:0] cap;

  always @(negedge clk) begin
    if (!rstN) begin
      inFrame = 0;
    end else begin
      if (drvEnable !== ~txSerial) r3Bad++;
      if (txSerial === 1'b0 && rxIntMask !== 1'b1) r7Bad++;
      if (testDone) nTest++;
      if (!inFrame && txSerial == 1'b0) begin
        inFrame = 1;
        monCnt = 0;
      end
      if (inFrame) begin
        if (monCnt % CPB == CPB / 2) cap[monCnt / CPB] = txSerial;
        if (monCnt == 10 * CPB - 1) begin
          if (nDec < 512) dec[nDec] = cap[8:1];
          nDec++;
          if (cap[0] !== 1'b0 || cap[9] !== 1'b1) frameErrs++;
          inFrame = 0;
        end
        monCnt++;
      end
    end
  end

  logic [7:0] txBuf [0:511];

  task automatic sendMsg(input int n, output bit aborted);
    aborted = 0;
    for (int i = 0; i < n; i++) begin
      reqValid = 1'b1;
      reqData  = txBuf[i];
      reqLast  = (i == n - 1);
      while (!reqReady && !sendAbort) @(negedge clk);
      if (sendAbort) break;
      @(negedge clk);
    end
    reqValid = 1'b0;
    reqLast  = 1'b0;
    while (!sendDone && !sendAbort) @(negedge clk);
    aborted = sendAbort;
    @(negedge clk);
  endtask

  task automatic runSelfTest();
    selfTestGo = 1'b1;
    @(negedge clk);
    selfTestGo = 1'b0;
    for (int i = 0; i < 100 && !testDone; i++) @(negedge clk);
    chk(testDone === 1'b1, "R8", "testDone pulse", testDone, 1);
    repeat (50) @(negedge clk);
    nDec = 0;
    frameErrs = 0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired act=%0d exp=%0d", 1, 0);
    finishRun();
  end

  initial begin
    bit ab;
    int cnt;
    int bad;
    int seen;
    int t0;

    // R1: reset values
    repeat (3) @(negedge clk);
    chk(txSerial === 1'b1, "R1", "txSerial in reset", txSerial, 1);
    chk(drvEnable === 1'b0, "R1", "drvEnable in reset", drvEnable, 0);
    chk(reqReady === 1'b0, "R1", "reqReady in reset", reqReady, 0);
    chk(rxIntMask === 1'b0, "R1", "rxIntMask in reset", rxIntMask, 0);
    chk(collisionFlag === 1'b0 && lineFault === 1'b0, "R1", "flags in reset",
        int'({collisionFlag, lineFault}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(sendDone === 1'b0 && sendAbort === 1'b0 && testDone === 1'b0, "R1", "pulses after reset",
        int'({sendDone, sendAbort, testDone}), 0);
    chk(txSerial === 1'b1, "R1", "txSerial after reset", txSerial, 1);
    repeat (20) @(negedge clk);

    // R2 R5 R7: single byte, mask while sending
    txBuf[0] = 8'hA5;
    nDec = 0; frameErrs = 0;
    fork
      sendMsg(1, ab);
      begin
        while (txSerial !== 1'b0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(rxIntMask === 1'b1, "R7", "mask during character", rxIntMask, 1);
      end
    join
    chk(!ab, "R5", "single byte completes", ab, 0);
    chk(nDec == 1, "R2", "one character", nDec, 1);
    chk(dec[0] == 8'hA5, "R2", "byte value lsb first", dec[0], 8'hA5);
    chk(frameErrs == 0, "R2", "start/stop levels", frameErrs, 0);
    chk(rxIntMask === 1'b0, "R7", "mask released when idle", rxIntMask, 0);

    // R2 R5: every byte value in one long message
    for (int i = 0; i < 256; i++) txBuf[i] = 8'(i);
    repeat (20) @(negedge clk);
    nDec = 0; frameErrs = 0;
    sendMsg(256, ab);
    chk(!ab, "R5", "256-byte message done", ab, 0);
    chk(nDec == 256, "R5", "character count", nDec, 256);
    bad = 0;
    for (int i = 0; i < 256; i++) if (dec[i] != 8'(i)) bad++;
    chk(bad == 0, "R2", "exhaustive byte sweep mismatches", bad, 0);
    chk(frameErrs == 0, "R2", "sweep framing", frameErrs, 0);

    // R4: idle qualification
    repeat (20) @(negedge clk);
    extBusy = 1'b1;
    repeat (5) @(negedge clk);
    txBuf[0] = 8'h3C;
    nDec = 0; frameErrs = 0;
    fork
      sendMsg(1, ab);
      begin
        seen = 0;
        for (int i = 0; i < 60; i++) begin
          @(negedge clk);
          if (txSerial === 1'b0 || reqReady === 1'b1) seen++;
        end
        chk(seen == 0, "R4", "no access while busy", seen, 0);
        extBusy = 1'b0;
        repeat (IWIN - 4) @(negedge clk);
        extBusy = 1'b1;
        seen = 0;
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          if (txSerial === 1'b0) seen++;
        end
        chk(seen == 0, "R4", "short free gap ignored", seen, 0);
        extBusy = 1'b0;
        cnt = 0;
        while (txSerial !== 1'b0 && cnt < 200) begin
          @(negedge clk);
          cnt++;
        end
        chk(cnt >= IWIN && cnt <= IWIN + 5, "R4", "start latency after free", cnt, IWIN + 4);
      end
    join
    chk(nDec == 1 && dec[0] == 8'h3C, "R4", "byte after qualification", dec[0], 8'h3C);

    // R6: collision timed into the first stop bit
    repeat (20) @(negedge clk);
    txBuf[0] = 8'h81; txBuf[1] = 8'h42; txBuf[2] = 8'h24;
    nDec = 0; frameErrs = 0;
    fork
      sendMsg(3, ab);
      begin
        while (txSerial !== 1'b0) @(negedge clk);
        repeat (37) @(negedge clk);
        extBusy = 1'b1;
      end
    join
    chk(ab, "R6", "abort reported", ab, 1);
    chk(nDec == 1 + JAM, "R6", "first byte plus jam count", nDec, 1 + JAM);
    chk(dec[0] == 8'h81, "R6", "first byte intact", dec[0], 8'h81);
    bad = 0;
    for (int i = 1; i <= JAM; i++) if (dec[i] != 8'h00) bad++;
    chk(bad == 0, "R6", "jam characters are zero", bad, 0);
    chk(collisionFlag === 1'b1, "R6", "collision flag held", collisionFlag, 1);
    chk(rxIntMask === 1'b0, "R7", "mask off after abort", rxIntMask, 0);
    repeat (10) @(negedge clk);
    extBusy = 1'b0;
    chk(collisionFlag === 1'b1, "R6", "flag held while idle", collisionFlag, 1);

    // R6: next message clears the flag
    txBuf[0] = 8'h5A;
    nDec = 0;
    fork
      sendMsg(1, ab);
      begin
        while (txSerial !== 1'b0) @(negedge clk);
        chk(collisionFlag === 1'b0, "R6", "flag cleared by new message", collisionFlag, 0);
      end
    join
    chk(!ab && dec[0] == 8'h5A, "R6", "retry byte sent", dec[0], 8'h5A);

    // R8: self-test on a working and a broken line
    repeat (50) @(negedge clk);
    runSelfTest();
    chk(lineFault === 1'b0, "R8", "healthy line no fault", lineFault, 0);
    lineBroken = 1'b1;
    runSelfTest();
    chk(lineFault === 1'b1, "R8", "broken line flagged", lineFault, 1);
    lineBroken = 1'b0;
    runSelfTest();
    chk(lineFault === 1'b0, "R8", "fault cleared on retest", lineFault, 0);

    // R9: self-test request during a message is ignored
    txBuf[0] = 8'hC3; txBuf[1] = 8'h1E;
    nDec = 0; frameErrs = 0;
    t0 = nTest;
    fork
      sendMsg(2, ab);
      begin
        while (txSerial !== 1'b0) @(negedge clk);
        repeat (10) @(negedge clk);
        selfTestGo = 1'b1;
        @(negedge clk);
        selfTestGo = 1'b0;
      end
    join
    repeat (10) @(negedge clk);
    chk(nTest == t0, "R9", "no testDone during message", nTest - t0, 0);
    chk(lineFault === 1'b0, "R9", "lineFault unchanged", lineFault, 0);
    chk(nDec == 2 && dec[0] == 8'hC3 && dec[1] == 8'h1E, "R9", "message intact", nDec, 2);

    // R3 R7: per-cycle tallies
    chk(r3Bad == 0, "R3", "enable not inverse of data", r3Bad, 0);
    chk(r7Bad == 0, "R7", "drive without mask", r7Bad, 0);

    finishRun();
  end

endmodule